// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Engine

This block is a single channel of a descriptor-driven DMA controller. Software places a linked list of descriptors in memory and writes the address of the first one into the channel's next-pointer register. Each descriptor occupies eight 32-bit words at a 32-byte aligned address. Word 0 is the link to the following descriptor, word 1 is the payload address, word 2 is the payload length, and word 3 carries a status byte in its top eight bits with user data below it. The channel reads the first four words of each descriptor through a word-wide request/acknowledge memory port. It hands the payload address and length to a beat generator, and when the payload has been issued it writes the status word back with the done flag set.

Flags in a descriptor's status byte decide three things: whether the channel raises its interrupt when that descriptor completes, whether the chain stops there, and which packet markers are carried along. A badly aligned link pointer halts the channel with an error flag and raises the interrupt. The interrupt output is a level signal, gated by a master enable. The beat generator here is a stub. It emits one beat address per cycle in place of real data movement.

Top module: `sg_chain_engine`

## Requirements
- R1: Writing a non-zero, 32-byte aligned value to the next-pointer register (register index 0) while the channel is idle starts a fetch of descriptor words 0 to 3 at that address, in that order. The busy flag (bit 25 of the status register, index 4) reads 1 from the cycle after that write until the chain stops or halts.
- R2: For each descriptor, beats are issued at the payload address and then every 4 bytes after it. There are ceil(L/4) beats, where L is the low 24 bits of the size word; the upper 8 bits of the size word are ignored.
- R3: On completion, word 3 of the descriptor is rewritten. Its low 24 bits are kept unchanged. In its top byte, done (bit 28) is set; error (31), busy (25) and reset (24) are cleared; interrupt-on-end (30), stop-on-end (29), start-of-packet (27) and end-of-packet (26) keep the values read from memory.
- R4: After a descriptor completes, a zero link pointer ends the chain. A non-zero aligned link pointer makes the channel fetch that descriptor next.
- R5: A descriptor with stop-on-end set ends the chain after it completes, even when its link pointer is non-zero. The next-pointer register then shows that link.
- R6: A completed descriptor with interrupt-on-end set sets the pending bit (bit 0 of the interrupt register, index 5).
- R7: A non-zero link pointer with any of its low 5 bits set is invalid. This applies to a pointer written to the register or one read from a descriptor. On an invalid pointer the channel sets error (status bit 31), clears busy, fetches nothing more and sets the pending bit.
- R8: The irq output equals pending AND the master enable (interrupt register bit 31). Writing 1 to bit 0 clears pending. Pending otherwise stays set.
- R9: Writing a status word with bit 24 set returns the channel to idle at once. Busy, the status flags, next pointer, current address, remaining size and current descriptor (indexes 0 to 4) then read 0, and no further beats appear.
- R10: A write to the next-pointer register while the channel is busy is ignored.
- R11: Register index 1 reads the current beat address, index 2 the remaining byte count, and index 3 the address of the descriptor being worked on. The status register holds its flag byte in bits 31:24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| beat_valid | output | 1 | A transfer beat is issued this cycle |
| beat_addr | output | 32 | Address of the current beat |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach from the ports is a channel reset that arrives in the middle of a long payload. At that moment the walker is waiting on the beat generator, with a memory acknowledge possibly still in flight. The bench starts a 64-beat descriptor and lets about ten beats pass. It then tries a next-pointer write, which must be ignored, and follows it with the reset write. After that it confirms that the registers read zero and that the scoreboard's outstanding beat count stays frozen. A second hard case is the error halt triggered by a misaligned link read from memory. This only happens after a full fetch, payload and write-back, so the bench builds a descriptor whose link is deliberately misaligned.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        W_IDLE,
        W_RD_NEXT,
        W_RD_ADDR,
        W_RD_SIZE,
        W_RD_STAT,
        W_XFER,
        W_WRBACK,
        W_CHAIN
    } walk_st_e;

    // bit positions inside the status byte (top byte of word 3)
    localparam int FL_ERR  = 7;
    localparam int FL_IOE  = 6;
    localparam int FL_SOE  = 5;
    localparam int FL_DONE = 4;
    localparam int FL_SOP  = 3;
    localparam int FL_EOP  = 2;
    localparam int FL_BUSY = 1;
    localparam int FL_RST  = 0;

    localparam int FLAG_LSB = 24;

    // register indexes
    localparam logic [2:0] RA_NEXT  = 3'd0;
    localparam logic [2:0] RA_CADDR = 3'd1;
    localparam logic [2:0] RA_CSIZE = 3'd2;
    localparam logic [2:0] RA_CDESC = 3'd3;
    localparam logic [2:0] RA_STAT  = 3'd4;
    localparam logic [2:0] RA_IRQ   = 3'd5;
endpackage

// File: rtl/sgc_beat_stub.sv
module sgc_beat_stub #(
    parameter int AW         = 32,
    parameter int LEN_W      = 24,
    parameter int BEAT_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             start,
    input  logic [AW-1:0]    start_addr,
    input  logic [LEN_W-1:0] start_len,
    output logic             beat_valid,
    output logic [AW-1:0]    beat_addr,
    output logic [LEN_W-1:0] remaining,
    output logic             done
);
    localparam logic [LEN_W-1:0] STEP = LEN_W'(BEAT_BYTES);

    typedef struct packed {
        logic             active;
        logic [AW-1:0]    addr;
        logic [LEN_W-1:0] rem;
    } stub_s;

    stub_s q, d;

    always_comb begin
        d          = q;
        beat_valid = q.active && (q.rem != '0);
        done       = q.active && (q.rem == '0);
        beat_addr  = q.addr;
        remaining  = q.rem;
        if (abort) begin
            d = '0;
        end else if (start) begin
            d.active = 1'b1;
            d.addr   = start_addr;
            d.rem    = start_len;
        end else if (beat_valid) begin
            d.addr = q.addr + AW'(BEAT_BYTES);
            d.rem  = (q.rem < STEP) ? '0 : q.rem - STEP;
        end else if (done) begin
            d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_NO_BEAT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> !beat_valid); // R2
endmodule

// File: rtl/sgc_irq.sv
module sgc_irq #(
    parameter int DW      = 32,
    parameter int MIE_BIT = 31,
    parameter int PND_BIT = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          set_evt,
    output logic          mie,
    output logic          pend,
    output logic          irq
);
    typedef struct packed {
        logic mie;
        logic pend;
    } irq_s;

    irq_s q, d;
    logic clr_hit;

    always_comb begin
        d       = q;
        clr_hit = cfg_we && cfg_wdata[PND_BIT];
        if (cfg_we) d.mie = cfg_wdata[MIE_BIT];
        if (set_evt)      d.pend = 1'b1;
        else if (clr_hit) d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mie  = q.mie;
    assign pend = q.pend;
    assign irq  = q.mie && q.pend;

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        q.pend && !clr_hit |=> q.pend); // R8
endmodule

// File: rtl/sgc_walker.sv
module sgc_walker
    import sgc_pkg::*;
#(
    parameter int AW      = 32,
    parameter int LEN_W   = 24,
    parameter int ALIGN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic [AW-1:0]     start_ptr,
    input  logic              chan_rst,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              xfer_start,
    output logic [AW-1:0]     xfer_addr,
    output logic [LEN_W-1:0]  xfer_len,
    input  logic              xfer_done,
    output logic [AW-1:0]     next_ptr,
    output logic [AW-1:0]     cur_desc,
    output logic [7:0]        flags,
    output logic              irq_evt
);
    localparam int USER_W = WORD_W - 8;
    localparam logic [AW-1:0] OFF_NEXT = AW'(0);
    localparam logic [AW-1:0] OFF_ADDR = AW'(4);
    localparam logic [AW-1:0] OFF_SIZE = AW'(8);
    localparam logic [AW-1:0] OFF_STAT = AW'(12);

    typedef struct packed {
        walk_st_e          st;
        logic [AW-1:0]     next_ptr;
        logic [AW-1:0]     cur_desc;
        logic [AW-1:0]     buf_addr;
        logic [LEN_W-1:0]  buf_len;
        logic [7:0]        flags;
        logic [USER_W-1:0] user;
    } walk_s;

    walk_s q, d;
    logic [7:0] wb_flags;

    function automatic logic bad_align(input logic [AW-1:0] p);
        return |p[ALIGN_W-1:0];
    endfunction

    always_comb begin
        wb_flags          = q.flags;
        wb_flags[FL_ERR]  = 1'b0;
        wb_flags[FL_DONE] = 1'b1;
        wb_flags[FL_BUSY] = 1'b0;
        wb_flags[FL_RST]  = 1'b0;
    end

    always_comb begin
        d          = q;
        irq_evt    = 1'b0;
        xfer_start = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = q.cur_desc;
        mem_wdata  = {wb_flags, q.user};
        unique case (q.st)
            W_IDLE: begin
                if (start_wr) begin
                    d.next_ptr = start_ptr;
                    if (start_ptr != '0) begin
                        d.flags = '0;
                        if (bad_align(start_ptr)) begin
                            d.flags[FL_ERR] = 1'b1;
                            irq_evt = 1'b1;
                        end else begin
                            d.flags[FL_BUSY] = 1'b1;
                            d.cur_desc = start_ptr;
                            d.st = W_RD_NEXT;
                        end
                    end
                end
            end
            W_RD_NEXT: begin
                mem_req  = 1'b1;
                mem_addr = q.cur_desc + OFF_NEXT;
                if (mem_ack) begin
                    d.next_ptr = mem_rdata[AW-1:0];
                    d.st = W_RD_ADDR;
                end
            end
            W_RD_ADDR: begin
                mem_req  = 1'b1;
                mem_addr = q.cur_desc + OFF_ADDR;
                if (mem_ack) begin
                    d.buf_addr = mem_rdata[AW-1:0];
                    d.st = W_RD_SIZE;
                end
            end
            W_RD_SIZE: begin
                mem_req  = 1'b1;
                mem_addr = q.cur_desc + OFF_SIZE;
                if (mem_ack) begin
                    d.buf_len = mem_rdata[LEN_W-1:0];
                    d.st = W_RD_STAT;
                end
            end
            W_RD_STAT: begin
                mem_req  = 1'b1;
                mem_addr = q.cur_desc + OFF_STAT;
                if (mem_ack) begin
                    d.user           = mem_rdata[USER_W-1:0];
                    d.flags[FL_IOE]  = mem_rdata[FLAG_LSB+FL_IOE];
                    d.flags[FL_SOE]  = mem_rdata[FLAG_LSB+FL_SOE];
                    d.flags[FL_SOP]  = mem_rdata[FLAG_LSB+FL_SOP];
                    d.flags[FL_EOP]  = mem_rdata[FLAG_LSB+FL_EOP];
                    d.flags[FL_DONE] = 1'b0;
                    xfer_start = 1'b1;
                    d.st = W_XFER;
                end
            end
            W_XFER: begin
                if (xfer_done) d.st = W_WRBACK;
            end
            W_WRBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = q.cur_desc + OFF_STAT;
                if (mem_ack) begin
                    d.flags[FL_DONE] = 1'b1;
                    irq_evt = q.flags[FL_IOE];
                    d.st = W_CHAIN;
                end
            end
            W_CHAIN: begin
                if (q.flags[FL_SOE] || q.next_ptr == '0) begin
                    d.flags[FL_BUSY] = 1'b0;
                    d.st = W_IDLE;
                end else if (bad_align(q.next_ptr)) begin
                    d.flags[FL_ERR]  = 1'b1;
                    d.flags[FL_BUSY] = 1'b0;
                    irq_evt = 1'b1;
                    d.st = W_IDLE;
                end else begin
                    d.cur_desc = q.next_ptr;
                    d.flags[FL_DONE] = 1'b0;
                    d.st = W_RD_NEXT;
                end
            end
            default: d.st = W_IDLE;
        endcase
        if (chan_rst) begin
            d       = '0;
            irq_evt = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign xfer_addr = q.buf_addr;
    assign xfer_len  = q.buf_len;
    assign next_ptr  = q.next_ptr;
    assign cur_desc  = q.cur_desc;
    assign flags     = q.flags;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack && !chan_rst |=> mem_req && $stable(mem_addr)); // R1
    AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.flags[FL_ERR]) |-> !q.flags[FL_BUSY]); // R7
    AST_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst |=> q.st == W_IDLE && !q.flags[FL_BUSY]); // R9
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        q.st == W_XFER && start_wr && !xfer_done && !chan_rst |=> $stable(q.next_ptr)); // R10
endmodule

// File: rtl/sg_chain_engine.sv
module sg_chain_engine
    import sgc_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LEN_W      = 24,
    parameter int ALIGN_W    = 5,
    parameter int BEAT_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          beat_valid,
    output logic [AW-1:0] beat_addr,
    output logic          irq
);
    logic             start_wr, chan_rst, irq_we;
    logic             xfer_start, xfer_done, irq_evt;
    logic [AW-1:0]    xfer_addr, next_ptr, cur_desc;
    logic [LEN_W-1:0] xfer_len, remaining;
    logic [7:0]       flags;
    logic             mie, pend;

    assign start_wr = reg_we && reg_addr == RA_NEXT;
    assign chan_rst = reg_we && reg_addr == RA_STAT && reg_wdata[FLAG_LSB+FL_RST];
    assign irq_we   = reg_we && reg_addr == RA_IRQ;

    sgc_walker #(.AW(AW), .LEN_W(LEN_W), .ALIGN_W(ALIGN_W)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .start_wr(start_wr), .start_ptr(reg_wdata[AW-1:0]), .chan_rst(chan_rst),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .xfer_start(xfer_start), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
        .xfer_done(xfer_done),
        .next_ptr(next_ptr), .cur_desc(cur_desc), .flags(flags), .irq_evt(irq_evt)
    );

    sgc_beat_stub #(.AW(AW), .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES)) u_stub (
        .clk(clk), .rst_n(rst_n), .abort(chan_rst),
        .start(xfer_start), .start_addr(xfer_addr), .start_len(xfer_len),
        .beat_valid(beat_valid), .beat_addr(beat_addr),
        .remaining(remaining), .done(xfer_done)
    );

    sgc_irq #(.DW(32)) u_irq (
        .clk(clk), .rst_n(rst_n), .cfg_we(irq_we), .cfg_wdata(reg_wdata),
        .set_evt(irq_evt), .mie(mie), .pend(pend), .irq(irq)
    );

    always_comb begin
        unique case (reg_addr)
            RA_NEXT:  reg_rdata = 32'(next_ptr);
            RA_CADDR: reg_rdata = 32'(beat_addr);
            RA_CSIZE: reg_rdata = 32'(remaining);
            RA_CDESC: reg_rdata = 32'(cur_desc);
            RA_STAT:  reg_rdata = {flags, 24'd0};
            RA_IRQ:   reg_rdata = {mie, 30'd0, pend};
            default:  reg_rdata = '0;
        endcase
    end

    AST_BEAT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> flags[FL_BUSY]); // R2
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pend); // R8
endmodule

// File: tb/sg_chain_engine_test.sv
module sg_chain_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = 32'd0;
    logic        beat_valid;
    logic [31:0] beat_addr;
    logic        irq;

    logic [31:0] mem [64];
    logic        ld_en = 1'b0;
    logic [5:0]  ld_idx = 6'd0;
    logic [31:0] ld_val = 32'd0;

    int n_chk = 0, n_fail = 0, sb_chk = 0, sb_fail = 0;
    bit wd_fail = 1'b0, finished = 1'b0;
    logic [31:0] exp_q [$];
    logic [31:0] sb_e;

    always #2.5 clk = ~clk;

    sg_chain_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .beat_valid(beat_valid), .beat_addr(beat_addr), .irq(irq)
    );

    // memory model: acknowledge one cycle after a request
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (ld_en) mem[ld_idx] <= ld_val;
        if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[7:2]];
            if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && beat_valid) begin
            sb_chk++;
            if (exp_q.size() == 0) begin
                sb_fail++;
                $display("FAIL R2 unexpected beat: actual %h expected none", beat_addr);
            end else begin
                sb_e = exp_q.pop_front();
                if (beat_addr !== sb_e) begin
                    sb_fail++;
                    $display("FAIL R2 beat address: actual %h expected %h", beat_addr, sb_e);
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic load(input int idx, input logic [31:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = 6'(idx); ld_val = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] base, input logic [31:0] nxt,
                            input logic [31:0] pa, input logic [31:0] sz,
                            input logic [31:0] w3);
        load(int'(base[7:2]),     nxt);
        load(int'(base[7:2]) + 1, pa);
        load(int'(base[7:2]) + 2, sz);
        load(int'(base[7:2]) + 3, w3);
    endtask

    // driver side of the scoreboard
    task automatic expect_beats(input logic [31:0] pa, input int nbytes);
        for (int i = 0; i < (nbytes + 3) / 4; i++) exp_q.push_back(pa + 32'(4 * i));
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd(3'd4, s);
            if (!s[25]) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed",
                 n_chk + sb_chk + int'(wd_fail), n_fail + sb_fail + int'(wd_fail));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            wd_fail = 1'b1;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int sz0;
        for (int i = 0; i < 64; i++) mem[i] = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(3'd4, v); chk("R11 status after reset", v, 32'h0);
        chk("R8 irq after reset", {31'd0, irq}, 32'd0);

        // two-descriptor chain, upper size bits ignored
        put_desc(32'h20, 32'h40, 32'h1000, 32'h0300000C, 32'h4000ABCD);
        put_desc(32'h40, 32'h0,  32'h2000, 32'h8,        32'h0C123456);
        expect_beats(32'h1000, 12);
        expect_beats(32'h2000, 8);
        wr(3'd0, 32'h20);
        rd(3'd4, v); chk("R1 busy after start", {31'd0, v[25]}, 32'd1);
        rd(3'd3, v); chk("R11 current descriptor", v, 32'h20);
        wait_idle();
        chk("R2 all chain beats seen", 32'(exp_q.size()), 32'd0);
        chk("R3 write-back first descriptor", mem[11], 32'h5000ABCD);
        chk("R4 second descriptor followed", mem[19], 32'h1C123456);
        rd(3'd4, v); chk("R4 status at chain end", v, 32'h1C000000);
        rd(3'd5, v); chk("R6 pending from interrupt-on-end", v, 32'h00000001);
        chk("R8 irq masked without enable", {31'd0, irq}, 32'd0);
        wr(3'd5, 32'h80000000);
        chk("R8 irq with enable", {31'd0, irq}, 32'd1);
        wr(3'd5, 32'h80000001);
        chk("R8 irq after clear", {31'd0, irq}, 32'd0);

        // stop-on-end with non-zero link
        put_desc(32'h60, 32'h20, 32'h3000, 32'h4, 32'h20000000);
        expect_beats(32'h3000, 4);
        wr(3'd0, 32'h60);
        wait_idle();
        chk("R5 single beat only", 32'(exp_q.size()), 32'd0);
        chk("R5 write-back", mem[27], 32'h30000000);
        rd(3'd0, v); chk("R5 next pointer shows link", v, 32'h20);
        chk("R6 no pending without flag", {31'd0, irq}, 32'd0);

        // misaligned pointer written to the register
        wr(3'd0, 32'h24);
        rd(3'd4, v); chk("R7 register misaligned error", v, 32'h80000000);
        chk("R7 irq on error", {31'd0, irq}, 32'd1);
        wr(3'd5, 32'h80000001);

        // misaligned link read from a descriptor
        put_desc(32'h80, 32'h44, 32'h4000, 32'h4, 32'h00000000);
        expect_beats(32'h4000, 4);
        wr(3'd0, 32'h80);
        wait_idle();
        rd(3'd4, v); chk("R7 descriptor link misaligned", v, 32'h90000000);
        chk("R7 irq on link error", {31'd0, irq}, 32'd1);
        chk("R3 write-back before error", mem[35], 32'h10000000);
        wr(3'd5, 32'h80000001);

        // channel reset in the middle of a long payload
        put_desc(32'hA0, 32'h0, 32'h5000, 32'h100, 32'h00000000);
        expect_beats(32'h5000, 256);
        wr(3'd0, 32'hA0);
        repeat (16) @(negedge clk);
        wr(3'd0, 32'h20);
        rd(3'd0, v); chk("R10 write while busy ignored", v, 32'h0);
        wr(3'd4, 32'h01000000);
        rd(3'd4, v); chk("R9 status after channel reset", v, 32'h0);
        rd(3'd1, v); chk("R9 current address cleared", v, 32'h0);
        rd(3'd2, v); chk("R9 remaining cleared", v, 32'h0);
        rd(3'd3, v); chk("R9 current descriptor cleared", v, 32'h0);
        sz0 = exp_q.size();
        repeat (12) @(negedge clk);
        chk("R9 beats stopped", 32'(exp_q.size()), 32'(sz0));
        chk("R9 reset came mid-payload", {31'd0, (sz0 > 0)}, 32'd1);
        exp_q.delete();

        finished = 1'b1;
        report();
        $finish;
    end
endmodule